// File: doc/BRIEF.md
# Byte Execution Unit with Zero and Carry Flags

This block is the execution stage of a small 8-bit soft processor. Each cycle it receives a first operand, a second operand (chosen between a register value and an immediate), an operation class, a two-bit function select and a literal shift count. It computes one of twelve functions and captures the result in an output register. The block also keeps its own zero and carry flag registers. These registers load only when the instruction being executed is allowed to write flags.

The carry flag means something different in each class. After an addition it holds the carry out. After a subtraction it holds the borrow out. After a logical function it is zero. After a shift or rotate it holds the bit that fell off the end of the byte. The carry-using arithmetic forms (add-with-carry and subtract-with-borrow) take their extra carry-in from the block's own carry flag register. A sequence of instructions can therefore build multi-byte sums with no outside help.

Top module: `byte_exec_unit`

## Requirements
- R1: Arithmetic class (`op_class`=00) with `op_fn`=00 gives A+B and `op_fn`=01 gives A+B+C. When flags are written, C becomes the carry out of bit 7.
- R2: Arithmetic class with `op_fn`=10 gives A−B and `op_fn`=11 gives A−B−C, both modulo 256. When flags are written, C becomes 1 exactly when the true difference is negative (a borrow).
- R3: The second operand B is `imm_b` when `use_imm`=1 and `reg_b` when `use_imm`=0.
- R4: Logical class (`op_class`=01) gives A AND B for `op_fn`=00, A OR B for 01, A XOR B for 10, and A AND NOT B for 11. Any logical operation that writes flags clears C. Class code 11 is decoded exactly like class 01.
- R5: Shift class (`op_class`=10) with `op_fn`=00 gives A shifted left by `shift_amt` and `op_fn`=01 gives A shifted right by `shift_amt`, zero-filled. C becomes the last bit shifted out: A[8−n] for a left shift and A[n−1] for a right shift.
- R6: Shift class with `op_fn`=10 rotates A left by n and `op_fn`=11 rotates A right by n. C becomes the last bit carried around the end: A[8−n] for a left rotate and A[n−1] for a right rotate.
- R7: With the shift class and `shift_amt`=0, the result equals A for every `op_fn`, and a flag write clears C.
- R8: On a flag write, Z becomes 1 exactly when the 8-bit result of that operation is zero. This holds in every class.
- R9: When `flag_we`=0, Z and C keep their values. The result register still updates.
- R10: One clock edge after an operation is presented, `result`, `zero_flag` and `carry_flag` show its outcome. A synchronous reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | 00 arithmetic, 01 logical, 10 shift/rotate, 11 decoded as logical |
| op_fn | input | 2 | Function within the class |
| src_a | input | 8 | First operand |
| reg_b | input | 8 | Second operand from the register path |
| imm_b | input | 8 | Second operand from the immediate path |
| use_imm | input | 1 | Selects the immediate as the second operand |
| shift_amt | input | 3 | Literal shift or rotate count, 0 to 7 |
| flag_we | input | 1 | Allows Z and C to load on this edge |
| result | output | 8 | Registered result |
| zero_flag | output | 1 | Registered Z flag |
| carry_flag | output | 1 | Registered C flag (carry, borrow or shifted-out bit) |

## Verification
The only state inside the unit is the pair of flag registers, and the result register captures a new value on every edge. A wrong carry is therefore hidden until the next carry-using arithmetic operation, where it moves the result by exactly one. The bench forces C to a known value just before every add-with-carry and subtract-with-borrow, so a carry fault shows in the very next result. A fault in flag gating or in Z generation shows on the flag ports one edge after the operation. The bench checks this on both written and suppressed cycles.

// File: rtl/byte_exec_pkg.sv
package byte_exec_pkg;
  typedef enum logic [1:0] {
    CLS_ARITH = 2'b00,
    CLS_LOGIC = 2'b01,
    CLS_SHIFT = 2'b10,
    CLS_ALIAS = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_XOR  = 2'b10,
    FN_MASK = 2'b11
  } logic_fn_e;
endpackage

// File: rtl/bx_arith.sv
module bx_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  input  logic         chain,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);
  logic         extra;
  logic [W:0]   wide;

  assign extra = chain & cin;

  always_comb begin
    if (subtract)
      wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, extra};
    else
      wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, extra};
  end

  // bit W is the carry for addition and the borrow for subtraction
  assign y    = wide[W-1:0];
  assign cout = wide[W];
endmodule

// File: rtl/bx_logic.sv
module bx_logic
  import byte_exec_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (logic_fn_e'(fn))
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_MASK: y = a & ~b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/bx_shift.sv
module bx_shift #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    fn,
  output logic [W-1:0]  y,
  output logic          cout
);
  localparam int WW = 2 * W;

  // stage[k] holds the value after the first k binary stages
  logic [WW-1:0] lstage [CW+1];
  logic [WW-1:0] rstage [CW+1];

  assign lstage[0] = {{W{1'b0}}, a};
  assign rstage[0] = {a, {W{1'b0}}};

  for (genvar k = 0; k < CW; k++) begin : g_stage
    assign lstage[k+1] = cnt[k] ? (lstage[k] << (1 << k)) : lstage[k];
    assign rstage[k+1] = cnt[k] ? (rstage[k] >> (1 << k)) : rstage[k];
  end

  logic [WW-1:0] lw, rw;
  assign lw = lstage[CW];
  assign rw = rstage[CW];

  always_comb begin
    unique case (fn)
      2'b00: begin y = lw[W-1:0];                cout = lw[W];   end
      2'b01: begin y = rw[WW-1:W];               cout = rw[W-1]; end
      2'b10: begin y = lw[W-1:0] | lw[WW-1:W];   cout = lw[W];   end
      default: begin y = rw[WW-1:W] | rw[W-1:0]; cout = rw[W-1]; end
    endcase
  end
endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
  import byte_exec_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    op_class,
  input  logic [1:0]    op_fn,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  reg_b,
  input  logic [W-1:0]  imm_b,
  input  logic          use_imm,
  input  logic [CW-1:0] shift_amt,
  input  logic          flag_we,
  output logic [W-1:0]  result,
  output logic          zero_flag,
  output logic          carry_flag
);
  logic [W-1:0] opnd_b;
  logic [W-1:0] ar_y, lg_y, sh_y, nxt_y;
  logic         ar_c, sh_c, nxt_c;

  assign opnd_b = use_imm ? imm_b : reg_b;

  bx_arith #(.W(W)) u_arith (
    .a        (src_a),
    .b        (opnd_b),
    .subtract (op_fn[1]),
    .chain    (op_fn[0]),
    .cin      (carry_flag),
    .y        (ar_y),
    .cout     (ar_c)
  );

  bx_logic #(.W(W)) u_logic (
    .a  (src_a),
    .b  (opnd_b),
    .fn (op_fn),
    .y  (lg_y)
  );

  bx_shift #(.W(W), .CW(CW)) u_shift (
    .a    (src_a),
    .cnt  (shift_amt),
    .fn   (op_fn),
    .y    (sh_y),
    .cout (sh_c)
  );

  always_comb begin
    unique case (op_class_e'(op_class))
      CLS_ARITH: begin nxt_y = ar_y; nxt_c = ar_c; end
      CLS_SHIFT: begin nxt_y = sh_y; nxt_c = sh_c; end
      default:   begin nxt_y = lg_y; nxt_c = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      zero_flag  <= 1'b0;
      carry_flag <= 1'b0;
    end else begin
      result <= nxt_y;
      if (flag_we) begin
        zero_flag  <= (nxt_y == '0);
        carry_flag <= nxt_c;
      end
    end
  end
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    op_class,
  input logic [W-1:0]  src_a,
  input logic [CW-1:0] shift_amt,
  input logic          flag_we,
  input logic [W-1:0]  result,
  input logic          zero_flag,
  input logic          carry_flag
);
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> ($stable(zero_flag) && $stable(carry_flag)));

  p_logic_clears_c_r4: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_class[0]) |=> !carry_flag);

  p_zero_tracks_result_r8: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (zero_flag == (result == '0)));

  p_count_zero_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_class == 2'b10 && shift_amt == '0)
      |=> (result == $past(src_a) && !carry_flag));
endmodule

bind byte_exec_unit bx_checker #(.W(W), .CW(CW)) u_bx_checker (
  .clk        (clk),
  .rst        (rst),
  .op_class   (op_class),
  .src_a      (src_a),
  .shift_amt  (shift_amt),
  .flag_we    (flag_we),
  .result     (result),
  .zero_flag  (zero_flag),
  .carry_flag (carry_flag)
);

// File: tb/byte_exec_unit_test.sv
`timescale 1ns/1ps
module byte_exec_unit_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] op_class, op_fn;
  logic [7:0] src_a, reg_b, imm_b;
  logic       use_imm, flag_we;
  logic [2:0] shift_amt;
  logic [7:0] result;
  logic       zero_flag, carry_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int m_z = 0;
  int m_c = 0;

  always #2 clk = ~clk;

  byte_exec_unit uut (
    .clk(clk), .rst(rst), .op_class(op_class), .op_fn(op_fn),
    .src_a(src_a), .reg_b(reg_b), .imm_b(imm_b), .use_imm(use_imm),
    .shift_amt(shift_amt), .flag_we(flag_we),
    .result(result), .zero_flag(zero_flag), .carry_flag(carry_flag)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // expected value computed from the requirement text
  function automatic void model(input int cls, input int fn, input int a,
                                input int b, input int n, input int cin,
                                output int y, output int c);
    int t;
    if (cls == 0) begin
      if (fn < 2) begin
        t = a + b + ((fn == 1) ? cin : 0);
        y = t % 256; c = (t > 255) ? 1 : 0;
      end else begin
        t = a - b - ((fn == 3) ? cin : 0);
        y = (t + 512) % 256; c = (t < 0) ? 1 : 0;
      end
    end else if (cls == 2) begin
      if (n == 0) begin y = a; c = 0; end
      else case (fn)
        0: begin y = (a * (1 << n)) % 256; c = (a >> (8 - n)) % 2; end
        1: begin y = a / (1 << n);        c = (a >> (n - 1)) % 2; end
        2: begin y = ((a * (1 << n)) % 256) + a / (1 << (8 - n)); c = (a >> (8 - n)) % 2; end
        default: begin y = a / (1 << n) + ((a * (1 << (8 - n))) % 256); c = (a >> (n - 1)) % 2; end
      endcase
    end else begin
      case (fn)
        0: y = a & b;
        1: y = a | b;
        2: y = a ^ b;
        default: y = a & (255 - b);
      endcase
      c = 0;
    end
  endfunction

  task automatic run_op(input string tag, input int cls, input int fn,
                        input int a, input int b, input int imm, input bit ui,
                        input int n, input bit we);
    int y, c;
    @(negedge clk);
    op_class = cls[1:0]; op_fn = fn[1:0]; src_a = a[7:0];
    reg_b = b[7:0]; imm_b = imm[7:0]; use_imm = ui;
    shift_amt = n[2:0]; flag_we = we;
    model(cls, fn, a, ui ? imm : b, n, m_c, y, c);
    @(negedge clk);
    check({tag, " result"}, result, y);
    if (we) begin m_z = (y == 0) ? 1 : 0; m_c = c; end
    check({tag, " Z"}, zero_flag, m_z);
    check({tag, " C"}, carry_flag, m_c);
  endtask

  task automatic force_carry(input int cv);
    run_op("R1 setup", 0, 0, 255, cv, 0, 1'b0, 0, 1'b1);
  endtask

  initial begin : watchdog
    #700000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; op_class = 0; op_fn = 0; src_a = 0; reg_b = 0; imm_b = 0;
    use_imm = 0; shift_amt = 0; flag_we = 0;
    src_a = 8'hFF; reg_b = 8'h01; flag_we = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 reset result", result, 0);
    check("R10 reset Z", zero_flag, 0);
    check("R10 reset C", carry_flag, 0);
    rst = 1'b0;

    // R1 / R2: arithmetic sweep with both carry-in values
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 15)
        for (int fn = 0; fn < 4; fn++)
          for (int cv = 0; cv < 2; cv++) begin
            force_carry(cv);
            run_op(fn < 2 ? "R1 add" : "R2 sub", 0, fn, a, b, 0, 1'b0, 0, 1'b1);
          end
    force_carry(1);
    run_op("R1 addc wrap to zero R8", 0, 1, 8'hFF, 0, 0, 1'b0, 0, 1'b1);
    force_carry(1);
    run_op("R2 subc borrow", 0, 3, 0, 0, 0, 1'b0, 0, 1'b1);

    // R3: immediate versus register operand
    run_op("R3 imm", 0, 0, 10, 100, 5, 1'b1, 0, 1'b1);
    run_op("R3 reg", 0, 0, 10, 100, 5, 1'b0, 0, 1'b1);

    // R4: logical functions, including class alias 11
    for (int a = 0; a < 256; a += 5)
      for (int fn = 0; fn < 4; fn++) begin
        force_carry(1);
        run_op("R4 logic", 1, fn, a, (a * 7 + 3) % 256, 0, 1'b0, 0, 1'b1);
        force_carry(1);
        run_op("R4 alias", 3, fn, 255 - a, a, a, 1'b1, 0, 1'b1);
      end

    // R5 / R6 / R7: every count for every shift function
    for (int a = 0; a < 256; a += 3)
      for (int fn = 0; fn < 4; fn++)
        for (int n = 0; n < 8; n++) begin
          if (n == 0) force_carry(1);
          run_op(n == 0 ? "R7 count0" : (fn < 2 ? "R5 shift" : "R6 rotate"),
                 2, fn, a, 0, 0, 1'b0, n, 1'b1);
        end

    // R9: flags untouched without write enable, result still moves
    force_carry(1);
    run_op("R9 hold logic", 1, 0, 0, 0, 0, 1'b0, 0, 1'b0);
    run_op("R9 hold arith", 0, 0, 1, 1, 0, 1'b0, 0, 1'b0);
    run_op("R8 zero set", 1, 2, 8'h5A, 8'h5A, 0, 1'b0, 0, 1'b1);
    run_op("R9 hold shift", 2, 0, 8'h80, 0, 0, 1'b0, 1, 1'b0);
    run_op("R9 hold sub", 0, 2, 0, 1, 0, 1'b0, 0, 1'b0);

    // R10: synchronous reset mid-run clears flags
    force_carry(1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; m_z = 0; m_c = 0;
    check("R10 rerun result", result, 0);
    check("R10 rerun C", carry_flag, 0);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule